// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block gathers sixteen interrupt sources and presents one request at a time to a processor core. Each source has its own configuration word on a 16-bit register port. The word holds a 5-bit priority, a sensitivity select (edge or level) and a routing select (fast or normal request output). A mask register keeps chosen sources out of arbitration. Among the unmasked pending sources, the one with the lowest priority value wins. The winner's index is latched into a readable source register, and the chosen request output is raised.

The request output stays high, and the reported index stays frozen, until software writes 1 to the matching bit of the control register. That write also acknowledges the source: an edge-mode source drops its pending flag, while a level-mode source stays pending for as long as its line is high. Only after the request has been cleared does the block latch a new arbitration result.

A software interrupt register lets a driver be tested without external stimulus. Each written 1 is ORed into the matching input line, but only for sources in edge mode. In the default build every source is steered to the fast output, whatever its routing bit says, and the normal output is held low.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After a synchronous reset, both request outputs are low and the source register reads 0. The mask register reads 0xFFFF (all sources masked), and every configuration word reads 0x005F (priority 31, level mode, routed fast).
- R2: Configuration word i is at address i (0x00 to 0x0F). Its layout is: bits [4:0] priority, bit 5 edge mode (1 = edge), bit 6 route to fast output (1 = fast). Bits 15:7 are not stored and read as 0.
- R3: Among the pending, unmasked sources, the one with the numerically lowest priority is chosen. When priorities are equal, the lowest index wins.
- R4: A source whose bit is 1 in the mask register (address 0x10) never wins arbitration, even when it is pending.
- R5: An edge-mode source becomes pending on a rising edge of its combined line. It stays pending after the line falls, and its pending flag is cleared when its request is acknowledged.
- R6: A level-mode source is pending while its line is high. After an acknowledge, it is chosen again if the line is still high, and not chosen if the line is low.
- R7: Writing 1 to bit i of the software interrupt register (address 0x13) raises source i if it is in edge mode. For a level-mode source the write has no effect.
- R8: The software interrupt register (0x13) and the control register (0x12) always read as 0.
- R9: While a request is high, the request and the source index stay unchanged until 1 is written to the matching control bit: bit 0 for the fast output, bit 1 for the normal output. A write of 1 to the other bit has no effect. A new result is latched in the cycle after the clear.
- R10: With NORMAL_EN = 0 (the default), every source drives the fast output, even when its route bit is 0, and the normal output stays low.
- R11: The source register (address 0x11) reads {bit 4 = a request is active, bits 3:0 = latched winner index}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 16 | External interrupt lines, one per source |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational on reg_addr) |
| fast_req | output | 1 | Fast interrupt request |
| norm_req | output | 1 | Normal interrupt request |
| src_idx | output | 4 | Latched winner index |

## Verification
Some internal faults leave state wrong: an edge pending flag that survives its acknowledge, or one that is never set. Such a fault shows at the ports as a request that comes back, or never comes, within two cycles of the clear or of the input edge. A broken tie-break or a broken priority compare shows at once, as a wrong index in the first request after unmasking. A faulty hold shows as a change of src_idx while fast_req is high, which the bench provokes by raising a more urgent source in the middle of service. Writes to the software register for a level-mode source, and to the wrong clear bit, are followed by a look at the request output before the next stimulus.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int N_SRC  = 16;
    localparam int PRIO_W = 5;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 5;
    localparam int IDX_W  = $clog2(N_SRC);

    // Register addresses (configuration words occupy 0 .. N_SRC-1)
    localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(N_SRC);
    localparam logic [ADDR_W-1:0] A_SOURCE = ADDR_W'(N_SRC + 1);
    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(N_SRC + 2);
    localparam logic [ADDR_W-1:0] A_SWINT  = ADDR_W'(N_SRC + 3);

    typedef struct packed {
        logic              route_fast;
        logic              edge_mode;
        logic [PRIO_W-1:0] prio;
    } src_cfg_t;

    localparam int CFG_W = $bits(src_cfg_t);

    localparam src_cfg_t CFG_RESET = '{route_fast: 1'b1, edge_mode: 1'b0,
                                       prio: {PRIO_W{1'b1}}};

    typedef enum logic [1:0] {
        REQ_IDLE = 2'b00,
        REQ_FAST = 2'b01,
        REQ_NORM = 2'b10
    } req_state_t;

    function automatic logic [N_SRC-1:0] one_hot(input logic [IDX_W-1:0] idx);
        return N_SRC'(1) << idx;
    endfunction

endpackage

// File: rtl/irqc_src_detect.sv
module irqc_src_detect
    import irqc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic irq_i,
    input  logic sw_i,
    input  logic edge_mode_i,
    input  logic ack_i,
    output logic pend_o
);
    logic line_c;
    logic line_q;
    logic epend_q;
    logic rise_c;

    // Software requests only count for edge-mode sources
    assign line_c = irq_i | (sw_i & edge_mode_i);
    assign rise_c = line_c & ~line_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q  <= 1'b0;
            epend_q <= 1'b0;
        end else begin
            line_q <= line_c;
            if (edge_mode_i && rise_c)
                epend_q <= 1'b1;
            else if (ack_i)
                epend_q <= 1'b0;
        end
    end

    assign pend_o = edge_mode_i ? epend_q : irq_i;

    // R5: acknowledge without a fresh edge leaves no edge pending
    a_r5_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (ack_i && !(edge_mode_i && rise_c)) |=> !epend_q);

    // R5: a rising edge in edge mode is remembered
    a_r5_edge_sets: assert property (@(posedge clk) disable iff (rst)
        (edge_mode_i && rise_c) |=> epend_q);

endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
    import irqc_pkg::*;
(
    input  logic [N_SRC-1:0]  cand_i,
    input  logic [PRIO_W-1:0] prio_i [N_SRC],
    output logic              valid_o,
    output logic [IDX_W-1:0]  idx_o
);
    logic [PRIO_W-1:0] best;

    // Strict compare while scanning upward: ties keep the lower index (R3)
    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        best    = '1;
        for (int i = 0; i < N_SRC; i++) begin
            if (cand_i[i] && (!valid_o || prio_i[i] < best)) begin
                valid_o = 1'b1;
                best    = prio_i[i];
                idx_o   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irqc_pkg::*;
#(
    parameter bit NORMAL_EN = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_SRC-1:0]  irq_in,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              fast_req,
    output logic              norm_req,
    output logic [IDX_W-1:0]  src_idx
);
    src_cfg_t          cfg_q [N_SRC];
    logic [PRIO_W-1:0] prio_v [N_SRC];
    logic [N_SRC-1:0]  edge_v;
    logic [N_SRC-1:0]  mask_q;
    logic [N_SRC-1:0]  pend;
    logic [N_SRC-1:0]  cand;
    logic [N_SRC-1:0]  ack_v;
    logic [N_SRC-1:0]  sw_v;
    req_state_t        req_q;
    logic [IDX_W-1:0]  src_q;
    logic              req_any;
    logic              win_valid;
    logic [IDX_W-1:0]  win_idx;
    logic              win_fast;
    logic              clr_hit;
    logic              wr_cfg, wr_mask, wr_ctrl, wr_sw;

    assign wr_cfg  = reg_we && (reg_addr < ADDR_W'(N_SRC));
    assign wr_mask = reg_we && (reg_addr == A_MASK);
    assign wr_ctrl = reg_we && (reg_addr == A_CTRL);
    assign wr_sw   = reg_we && (reg_addr == A_SWINT);

    assign req_any = (req_q != REQ_IDLE);
    assign clr_hit = wr_ctrl && (((req_q == REQ_FAST) && reg_wdata[0]) ||
                                 ((req_q == REQ_NORM) && reg_wdata[1]));
    assign ack_v   = clr_hit ? one_hot(src_q) : '0;
    assign sw_v    = wr_sw ? reg_wdata[N_SRC-1:0] : '0;

    // Per-source detection
    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        assign prio_v[g] = cfg_q[g].prio;
        assign edge_v[g] = cfg_q[g].edge_mode;

        irqc_src_detect u_det (
            .clk        (clk),
            .rst        (rst),
            .irq_i      (irq_in[g]),
            .sw_i       (sw_v[g]),
            .edge_mode_i(edge_v[g]),
            .ack_i      (ack_v[g]),
            .pend_o     (pend[g])
        );
    end

    assign cand = pend & ~mask_q;

    irqc_arbiter u_arb (
        .cand_i (cand),
        .prio_i (prio_v),
        .valid_o(win_valid),
        .idx_o  (win_idx)
    );

    // Output routing variant
    if (NORMAL_EN) begin : g_route_cfg
        assign win_fast = cfg_q[win_idx].route_fast;
    end else begin : g_route_fast
        assign win_fast = 1'b1;
    end

    // Configuration and mask registers
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_SRC; i++) cfg_q[i] <= CFG_RESET;
            mask_q <= '1;
        end else begin
            if (wr_cfg)
                cfg_q[reg_addr[IDX_W-1:0]] <= src_cfg_t'(reg_wdata[CFG_W-1:0]);
            if (wr_mask)
                mask_q <= reg_wdata[N_SRC-1:0];
        end
    end

    // Request latch: a new winner only once the previous one is cleared
    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= REQ_IDLE;
            src_q <= '0;
        end else if (req_any) begin
            if (clr_hit) req_q <= REQ_IDLE;
        end else if (win_valid) begin
            req_q <= win_fast ? REQ_FAST : REQ_NORM;
            src_q <= win_idx;
        end
    end

    assign fast_req = (req_q == REQ_FAST);
    assign norm_req = (req_q == REQ_NORM);
    assign src_idx  = src_q;

    // Register read-back
    always_comb begin
        reg_rdata = '0;
        if (reg_addr < ADDR_W'(N_SRC))
            reg_rdata = DATA_W'(cfg_q[reg_addr[IDX_W-1:0]]);
        else if (reg_addr == A_MASK)
            reg_rdata = DATA_W'(mask_q);
        else if (reg_addr == A_SOURCE)
            reg_rdata = DATA_W'({req_any, src_q});
    end

    // R9: request and index hold until cleared
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (req_any && !clr_hit) |=> (req_any && $stable(src_q) && $stable(req_q)));

    // R9: clearing drops the request for at least one cycle
    a_r9_clear: assert property (@(posedge clk) disable iff (rst)
        clr_hit |=> !req_any);

    // R4: a freshly latched winner was an unmasked pending source
    a_r4_unmasked_winner: assert property (@(posedge clk) disable iff (rst)
        $rose(req_any) |-> (($past(cand) & one_hot(src_q)) != '0));

    // R3: arbiter result is one of the candidates
    a_r3_win_is_cand: assert property (@(posedge clk) disable iff (rst)
        win_valid |-> ((cand & one_hot(win_idx)) != '0));

    if (!NORMAL_EN) begin : g_chk_fast
        // R10: normal output never used in the fast-only build
        a_r10_no_norm: assert property (@(posedge clk) disable iff (rst)
            !norm_req);
    end

endmodule

// File: tb/irq_prio_ctrl_bench.sv
`timescale 1ns/1ps
module irq_prio_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] irq_in;
    logic        reg_we;
    logic [4:0]  reg_addr;
    logic [15:0] reg_wdata;
    logic [15:0] reg_rdata;
    logic        fast_req, norm_req;
    logic [3:0]  src_idx;

    int n_chk  = 0;
    int n_fail = 0;

    localparam logic [4:0] AD_MASK = 5'h10, AD_SRC = 5'h11,
                           AD_CTRL = 5'h12, AD_SW  = 5'h13;

    always #2 clk = ~clk;

    irq_prio_ctrl u_irq_prio_ctrl (
        .clk(clk), .rst(rst), .irq_in(irq_in), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .fast_req(fast_req), .norm_req(norm_req), .src_idx(src_idx)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic do_reset();
        rst = 1'b1; irq_in = '0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        tick(2);
        rst = 1'b0;
        tick(1);
    endtask

    task automatic t_reset();
        logic [15:0] d;
        do_reset();
        chk("R1 fast_req", 16'(fast_req), 16'h0);
        chk("R1 norm_req", 16'(norm_req), 16'h0);
        rd(AD_MASK, d); chk("R1 mask", d, 16'hFFFF);
        rd(5'h07, d);   chk("R1 cfg7", d, 16'h005F);
        rd(AD_SRC, d);  chk("R1 source", d, 16'h0000);
    endtask

    task automatic t_cfg();
        logic [15:0] d;
        do_reset();
        wr(5'h03, 16'h0025); rd(5'h03, d); chk("R2 cfg3 readback", d, 16'h0025);
        wr(5'h0F, 16'hFFFF); rd(5'h0F, d); chk("R2 cfg15 unused bits", d, 16'h007F);
    endtask

    task automatic t_prio();
        do_reset();
        wr(5'h05, 16'h0003); wr(5'h09, 16'h0001); wr(5'h0C, 16'h0001);
        irq_in = 16'h1220;
        wr(AD_MASK, 16'h0000);
        tick(2);
        chk("R3 tie lowest index", 16'(src_idx), 16'd9);
        chk("R3 fast_req", 16'(fast_req), 16'h1);
        wr(AD_CTRL, 16'h0001); tick(2);
        chk("R6 level re-chosen while high", 16'(src_idx), 16'd9);
        irq_in = 16'h1020; wr(AD_CTRL, 16'h0001); tick(2);
        chk("R3 next equal prio", 16'(src_idx), 16'd12);
        irq_in = 16'h0020; wr(AD_CTRL, 16'h0001); tick(2);
        chk("R3 lower prio last", 16'(src_idx), 16'd5);
        irq_in = 16'h0000; wr(AD_CTRL, 16'h0001); tick(3);
        chk("R6 level low not chosen", 16'(fast_req), 16'h0);
    endtask

    task automatic t_mask();
        logic [15:0] d;
        do_reset();
        wr(5'h02, 16'h0000); wr(5'h07, 16'h000A);
        irq_in = 16'h0084;
        wr(AD_MASK, 16'hFFFF); tick(3);
        chk("R4 all masked no request", 16'(fast_req), 16'h0);
        wr(AD_MASK, 16'h0004 ^ 16'hFFFF ^ 16'h0084); tick(2);
        chk("R4 masked source skipped", 16'(src_idx), 16'd7);
        rd(AD_SRC, d); chk("R11 source register", d, 16'h0017);
    endtask

    task automatic t_edge();
        do_reset();
        wr(5'h04, 16'h0022);
        wr(AD_MASK, 16'h0000);
        irq_in[4] = 1'b1; tick(1); irq_in[4] = 1'b0;
        tick(2);
        chk("R5 pulse latched", 16'(fast_req), 16'h1);
        chk("R5 index", 16'(src_idx), 16'd4);
        wr(AD_CTRL, 16'h0001); tick(3);
        chk("R5 cleared by ack", 16'(fast_req), 16'h0);
    endtask

    task automatic t_sw();
        logic [15:0] d;
        do_reset();
        wr(5'h04, 16'h0022); wr(5'h06, 16'h0002);
        wr(AD_MASK, 16'h0000);
        wr(AD_SW, 16'h0010); tick(2);
        chk("R7 sw edge raises", 16'(fast_req), 16'h1);
        chk("R7 sw edge index", 16'(src_idx), 16'd4);
        wr(AD_CTRL, 16'h0001); tick(3);
        chk("R7 sw edge cleared", 16'(fast_req), 16'h0);
        wr(AD_SW, 16'h0040); tick(3);
        chk("R7 sw level ignored", 16'(fast_req), 16'h0);
        rd(AD_SW, d);   chk("R8 swint reads zero", d, 16'h0);
        rd(AD_CTRL, d); chk("R8 ctrl reads zero", d, 16'h0);
    endtask

    task automatic t_hold();
        do_reset();
        wr(5'h01, 16'h0008); wr(5'h02, 16'h0001);
        wr(AD_MASK, 16'h0000);
        irq_in = 16'h0002; tick(2);
        chk("R9 first winner", 16'(src_idx), 16'd1);
        irq_in = 16'h0006; tick(3);
        chk("R9 index held", 16'(src_idx), 16'd1);
        wr(AD_CTRL, 16'h0002); tick(2);
        chk("R9 wrong clear bit ignored", 16'(fast_req), 16'h1);
        chk("R9 index still held", 16'(src_idx), 16'd1);
        wr(AD_CTRL, 16'h0001);
        chk("R9 request drops on clear", 16'(fast_req), 16'h0);
        tick(1);
        chk("R9 new winner after clear", 16'(src_idx), 16'd2);
    endtask

    task automatic t_route();
        do_reset();
        wr(5'h03, 16'h0000);
        wr(AD_MASK, 16'h0000);
        irq_in = 16'h0008; tick(2);
        chk("R10 route 0 still fast", 16'(fast_req), 16'h1);
        chk("R10 normal low", 16'(norm_req), 16'h0);
    endtask

    initial begin
        t_reset();
        t_cfg();
        t_prio();
        t_mask();
        t_edge();
        t_sw();
        t_hold();
        t_route();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule